// File: doc/BRIEF.md
# Indexed Indirect Effective Address Sequencer

This block turns one 36-bit single-address instruction word into its final 15-bit effective address. It pulls the operation code out of the word and keeps it. It then reads an index register held in main memory and adds that register to the base address. The adder is a ring adder: a carry out of the top bit is fed back into the lowest bit. If the indirect flag is set, the block reads the word at the current address and treats that word as a new address word. The new word supplies its own indirect flag, index field and base address, and the block applies indexing again before it looks at the new indirect flag. Chains of any length are followed until a programmed depth limit is reached.

The block uses a simple read port. It raises a request with an address and holds both until the memory answers with a valid strobe and a data word. When the address is complete, the block gives a one-cycle done pulse. The effective address, the operation code, the count of memory cycles used and a depth-error flag are presented with that pulse and held until the next start.

Top module: `ea_sequencer`

## Requirements
- R1: After reset the block is idle: busy, done, mem_req and depth_err are all zero.
- R2: The opcode output equals bits 35:30 of the instruction word given with start. The opcode bits of words fetched during indirection do not change it.
- R3: A 9-bit index field (bits 26:18) of zero causes no index read. A non-zero field causes one read at that field value, zero-extended to 15 bits. Bits 14:0 of the returned word are the index value.
- R4: Indexing replaces the address with base plus index in 15-bit ring arithmetic: a carry out of bit 14 is added into bit 0. For example, 0x7FFF plus 1 gives 0x0001.
- R5: When the indirect flag (bit 29) of the current word is one, the block reads the word at the current address. That word supplies a new indirect flag (bit 29), index field (bits 26:18) and base (bits 14:0). Indexing is applied to the new fields before the new indirect flag is examined.
- R6: Bits 17:15 are reserved. Their value has no effect on any output or memory address.
- R7: The cycles output equals one plus the number of memory reads made for this instruction.
- R8: Suppose the indirect flag is set while the number of indirect reads already made equals depth_limit. The block then makes no further read, sets depth_err and finishes. Its ea output is the address that would have been read. A depth_limit of zero therefore flags any indirect word.
- R9: While mem_req is high and mem_valid is low, mem_req stays high and mem_addr stays unchanged. Each valid strobe completes exactly one read.
- R10: done is high for exactly one cycle per instruction. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address formation for instr (sampled when idle) |
| instr | input | 36 | Instruction word |
| depth_limit | input | DW | Maximum number of indirect reads |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 15 | Memory read address |
| mem_valid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 36 | Read data word |
| busy | output | 1 | Sequencer is working on an instruction |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 15 | Final effective address |
| opcode | output | 6 | Operation code of the instruction |
| cycles | output | CW | Memory cycles used, instruction fetch included |
| depth_err | output | 1 | Indirect depth limit was reached |

## Verification
The stimulus covers these cases:
- A plain word with reserved bits set. This separates field decoding from any indexing or indirection.
- Indexed words whose sums do and do not carry out of bit 14. Only these show whether the carry is fed back into bit 0.
- Chains of one to several indirect words, each carrying its own index field and a foreign opcode. These show whether indexing is applied again at every level and whether the opcode is kept.
- Depth limits of zero and of values inside a chain. These check where the error cuts the chain off and the address reported when it does.
- Memory latencies of zero to three cycles, and a start pulse that arrives mid-run. These test the request hold and the rule that start is ignored while busy.

// File: rtl/ea_sequencer.sv
module ea_sequencer #(
  parameter int DW = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [35:0]   instr,
  input  logic [DW-1:0] depth_limit,
  output logic          mem_req,
  output logic [14:0]   mem_addr,
  input  logic          mem_valid,
  input  logic [35:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [14:0]   ea,
  output logic [5:0]    opcode,
  output logic [CW-1:0] cycles,
  output logic          depth_err
);
  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_IDX, S_IND, S_DONE} state_t;

  state_t        st;
  logic [14:0]   y;
  logic [8:0]    xsel;
  logic          ind, xdone;
  logic [DW-1:0] depth;
  logic [15:0]   raw_sum;
  logic [14:0]   ring_sum;

  assign raw_sum  = {1'b0, y} + {1'b0, mem_rdata[14:0]};
  assign ring_sum = raw_sum[14:0] + {14'd0, raw_sum[15]};

  assign mem_req  = (st == S_IDX) || (st == S_IND);
  assign mem_addr = (st == S_IDX) ? {6'd0, xsel} : y;
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign ea       = y;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      y <= '0;
      xsel <= '0;
      ind <= 1'b0;
      xdone <= 1'b0;
      depth <= '0;
      cycles <= '0;
      opcode <= '0;
      depth_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          opcode <= instr[35:30];
          ind <= instr[29];
          xsel <= instr[26:18];
          y <= instr[14:0];
          xdone <= 1'b0;
          depth <= '0;
          cycles <= CW'(1);
          depth_err <= 1'b0;
          st <= S_EVAL;
        end
        S_EVAL: begin
          if (xsel != 9'd0 && !xdone) st <= S_IDX;
          else if (!ind) st <= S_DONE;
          else if (depth == depth_limit) begin
            depth_err <= 1'b1;
            st <= S_DONE;
          end else st <= S_IND;
        end
        S_IDX: if (mem_valid) begin
          y <= ring_sum;
          xdone <= 1'b1;
          cycles <= cycles + CW'(1);
          st <= S_EVAL;
        end
        S_IND: if (mem_valid) begin
          ind <= mem_rdata[29];
          xsel <= mem_rdata[26:18];
          y <= mem_rdata[14:0];
          xdone <= 1'b0;
          depth <= depth + DW'(1);
          cycles <= cycles + CW'(1);
          st <= S_EVAL;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_sequencer_chk.sv
module ea_sequencer_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic [14:0]   mem_addr,
  input logic          mem_valid,
  input logic          busy,
  input logic          done,
  input logic [5:0]    opcode,
  input logic [CW-1:0] cycles,
  input logic          depth_err
);
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  a_r9_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_valid |=> !mem_req);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !done);

  a_r7_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_valid |=> cycles == $past(cycles) + CW'(1));

  a_r2_opcode_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(opcode));

  a_r8_err_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(depth_err) |-> done);
endmodule

bind ea_sequencer ea_sequencer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_valid(mem_valid), .busy(busy), .done(done), .opcode(opcode),
  .cycles(cycles), .depth_err(depth_err)
);

// File: tb/sim_ea_sequencer.sv
module sim_ea_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [35:0] instr = '0;
  logic [DW-1:0] depth_limit = '0;
  logic mem_req, mem_valid = 1'b0, busy, done, depth_err;
  logic [14:0] mem_addr, ea;
  logic [35:0] mem_rdata = '0;
  logic [5:0] opcode;
  logic [CW-1:0] cycles;

  ea_sequencer #(.DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .depth_limit(depth_limit), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .ea(ea), .opcode(opcode), .cycles(cycles), .depth_err(depth_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int lat = 0, wcnt = 0;
  logic [35:0] mem [int];
  int exp_q [$];
  int exp_ea, exp_cyc, exp_op, exp_err;

  function automatic logic [35:0] rd(int a);
    return mem.exists(a) ? mem[a] : 36'd0;
  endfunction

  function automatic logic [35:0] mk(int op, int ind, int x, int rsv, int y);
    logic [35:0] w;
    w = '0;
    w[35:30] = 6'(op); w[29] = ind[0]; w[26:18] = 9'(x);
    w[17:15] = 3'(rsv); w[14:0] = 15'(y);
    return w;
  endfunction

  task automatic chk(string req, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic model(logic [35:0] iw, int lim);
    logic [35:0] w;
    int y, x, lv, s;
    w = iw; lv = 0;
    exp_op = int'(iw[35:30]); exp_cyc = 1; exp_err = 0;
    exp_q.delete();
    forever begin
      x = int'(w[26:18]); y = int'(w[14:0]);
      if (x != 0) begin
        exp_q.push_back(x); exp_cyc++;
        s = y + int'(rd(x) & 36'h7FFF);
        if (s > 32767) s = s - 32768 + 1;
        y = s;
      end
      exp_ea = y;
      if (!w[29]) break;
      if (lv == lim) begin exp_err = 1; break; end
      exp_q.push_back(y); exp_cyc++; lv++;
      w = rd(y);
    end
  endtask

  always @(negedge clk) begin
    if (mem_valid) mem_valid <= 1'b0;
    else if (mem_req) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        mem_valid <= 1'b1;
        mem_rdata <= rd(int'(mem_addr));
        if (exp_q.size() == 0) chk("R3/R5 unexpected read", int'(mem_addr), -1);
        else chk("R3/R5 read address", int'(mem_addr), exp_q.pop_front());
      end else wcnt++;
    end
    if (mem_req && !busy) chk("R1 req while idle", 1, 0);
  end

  task automatic run(string tag, logic [35:0] iw, int lim, bit disturb);
    int t;
    model(iw, lim);
    @(negedge clk);
    instr = iw; depth_limit = DW'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      @(negedge clk); @(negedge clk);
      instr = mk(6'o77, 0, 0, 0, 15'h1234); start = 1'b1;
      @(negedge clk); start = 1'b0; instr = '0;
    end
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    if (!done) begin
      chk({tag, " watchdog"}, 0, 1);
    end else begin
      chk({tag, " R4/R5 ea"}, int'(ea), exp_ea);
      chk({tag, " R2 opcode"}, int'(opcode), exp_op);
      chk({tag, " R7 cycles"}, int'(cycles), exp_cyc);
      chk({tag, " R8 depth_err"}, int'(depth_err), exp_err);
      chk({tag, " R3 reads left"}, exp_q.size(), 0);
      @(negedge clk);
      chk({tag, " R10 done pulse"}, int'(done), 0);
      chk({tag, " R10 idle after"}, int'(busy), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 mem_req", int'(mem_req), 0);
    chk("R1 depth_err", int'(depth_err), 0);
    rst_n = 1'b1;

    mem[5] = 36'd100;
    mem[9] = mk(6'o55, 0, 0, 0, 15'h7FFF) | 36'o777777_000000;
    mem[32] = 36'h0_0000_7FF0 & 36'h7FFF;
    mem[511] = 36'd7;
    mem[3] = 36'd1;
    mem[15'h1000] = mk(6'o11, 0, 0, 5, 15'h0234);
    mem[15'h2000] = mk(6'o22, 1, 5, 0, 15'h0F00);
    mem[15'h0F64] = mk(6'o33, 1, 3, 7, 15'h2FFF);
    mem[15'h3000] = mk(6'o44, 0, 511, 0, 15'h0010);
    mem[15'h4000] = mk(0, 1, 0, 0, 15'h4001);
    mem[15'h4001] = mk(0, 1, 0, 0, 15'h4002);
    mem[15'h4002] = mk(0, 1, 0, 0, 15'h4003);
    mem[15'h4003] = mk(0, 1, 0, 0, 15'h4004);
    mem[15'h4004] = mk(0, 0, 0, 0, 15'h0042);

    for (int l = 0; l < 4; l++) begin
      lat = (l == 3) ? 3 : l;
      run("R6 direct", mk(6'o12, 0, 0, 7, 15'h1357), 4, 0);
      run("R3 R4 indexed", mk(6'o21, 0, 5, 0, 200), 4, 0);
      run("R4 ring wrap", mk(6'o01, 0, 3, 0, 15'h7FFF), 4, 0);
      run("R4 ring big", mk(6'o02, 0, 9, 2, 15'h7FF0), 4, 0);
      run("R3 max index", mk(6'o03, 0, 511, 0, 15'h0100), 4, 0);
      run("R5 single ind", mk(6'o04, 1, 0, 0, 15'h1000), 4, 0);
      run("R5 chain idx", mk(6'o05, 1, 0, 0, 15'h2000), 4, 0);
      run("R5 long chain", mk(6'o06, 1, 0, 0, 15'h4000), 9, 0);
      run("R8 limit mid", mk(6'o07, 1, 0, 0, 15'h4000), 2, 0);
      run("R8 limit zero", mk(6'o10, 1, 3, 0, 15'h1000), 0, 0);
      run("R8 limit exact", mk(6'o13, 1, 0, 0, 15'h4000), 5, 0);
      run("R10 start busy", mk(6'o14, 1, 0, 0, 15'h2000), 4, 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule